// File: doc/BRIEF.md
# Flash Program and Erase Sequencer

This block is a host-side controller for a byte-wide flash memory that needs unlock write sequences before it will change its contents. A single request selects one of three operations: byte program, sector erase or whole-bank erase. The controller then drives the unlock and command writes over a simple synchronous bus master and waits for the internal operation to finish. Each bus transfer is one strobe that stays asserted until the slave raises a ready input.

Completion is found in one of three ways. Toggle polling reads the target location repeatedly and looks for bit 6 to stop changing. Polarity polling compares bit 7 of each read with its final value. Timed mode issues no reads and waits out a programmed number of clocks. A read that passes may have landed while the operation was finishing, so the controller does not report success until two further reads in a row also pass. A per-operation timeout limit ends polling with an error. Requests that arrive while a sequence is running are refused.

Top module: `flash_seq_ctrl`

## Requirements
- R1: Program (op_i=0) issues exactly four writes as (address, data): (0x5555,0xAA), (0x2AAA,0x55), (0x5555,0xA0), (addr_i,data_i).
- R2: Sector erase (op_i=1) issues exactly six writes: (0x5555,0xAA), (0x2AAA,0x55), (0x5555,0x80), (0x5555,0xAA), (0x2AAA,0x55), then 0x30 at addr_i with its low 12 bits cleared.
- R3: Bank erase (op_i=2 or 3) issues the same first five writes as R2, then 0x10 at 0x5555.
- R4: In toggle mode (mode_i=0), all polling reads go to addr_i. A read passes when its bit 6 equals bit 6 of the previous read in the same poll. The first read of a poll is neither a pass nor a fail.
- R5: In polarity mode (mode_i=1), a read passes when its bit 7 equals data_i[7] for a program, or 1 for either erase. Any other value is a fail.
- R6: done_o pulses for one cycle after the third consecutive passing read, which is the first pass followed by two confirming reads. A failing read restarts the count.
- R7: The timeout limit is tmo_prog_i, tmo_sect_i or tmo_bank_i, chosen by the operation. A failing read that completes at least that many cycles after the last command write is accepted pulses err_o, and the controller returns to idle without done_o.
- R8: In timed mode (mode_i=2 or 3) no reads are issued, and done_o is high exactly limit cycles after the final command write is accepted.
- R9: A request while busy_o is high is ignored and pulses rej_o on the following cycle. The running sequence is unchanged.
- R10: A run of passing reads that is still building toward confirmation is not cut short by the timeout. It ends in done_o, or in err_o only on a later failing read.
- R11: Only one of bus_we_o and bus_re_o is high at a time. A strobe stays high with stable address and data until bus_rdy_i is seen.
- R12: After reset busy_o, done_o, err_o, rej_o, bus_we_o and bus_re_o are all low. busy_o is high from the cycle after an accepted request until done_o or err_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Start request |
| op_i | input | 2 | 0 program, 1 sector erase, 2/3 bank erase |
| mode_i | input | 2 | 0 toggle poll, 1 polarity poll, 2/3 timed |
| addr_i | input | AW | Target byte or sector address |
| data_i | input | 8 | Byte to program |
| tmo_prog_i | input | TW | Program limit in clocks |
| tmo_sect_i | input | TW | Sector erase limit in clocks |
| tmo_bank_i | input | TW | Bank erase limit in clocks |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Success pulse |
| err_o | output | 1 | Timeout pulse |
| rej_o | output | 1 | Refused request pulse |
| bus_addr_o | output | AW | Bus address |
| bus_wdata_o | output | 8 | Bus write data |
| bus_we_o | output | 1 | Write strobe |
| bus_re_o | output | 1 | Read strobe |
| bus_rdata_i | input | 8 | Read data, valid with ready |
| bus_rdy_i | input | 1 | Transfer accept |

## Verification
Two events can fall on the same read. The timeout limit can expire while passing reads are still being confirmed, and the flash can finish on the very read where the status bits look settled only by chance. The bench provokes the first case with a limit of one clock while the flash model is already finished, and expects done_o, not err_o. It provokes the second by making the model return one spurious passing status read in the middle of its busy period. The read count at done_o must then match a reference walk in which that glitch restarts the confirmation count.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;
  typedef enum logic [1:0] {OP_PROG = 2'd0, OP_SECT = 2'd1, OP_BANK = 2'd2} op_e;
  typedef enum logic [1:0] {POLL_TOGGLE = 2'd0, POLL_POLAR = 2'd1, POLL_WAIT = 2'd2} poll_e;
  typedef enum logic [1:0] {S_IDLE, S_CMD, S_READ, S_WAIT} st_e;

  localparam logic [14:0] UNLOCK_A = 15'h5555;
  localparam logic [14:0] UNLOCK_B = 15'h2AAA;
  localparam logic [7:0]  KEY_A    = 8'hAA;
  localparam logic [7:0]  KEY_B    = 8'h55;
  localparam logic [7:0]  CMD_PROG = 8'hA0;
  localparam logic [7:0]  CMD_ERS  = 8'h80;
  localparam logic [7:0]  CMD_SECT = 8'h30;
  localparam logic [7:0]  CMD_BANK = 8'h10;

  // suggested limits at a 100 MHz clock
  localparam int unsigned DEF_TMO_PROG = 2000;
  localparam int unsigned DEF_TMO_SECT = 2500000;
  localparam int unsigned DEF_TMO_BANK = 10000000;
endpackage

// File: rtl/flash_cmd_gen.sv
module flash_cmd_gen
  import flash_seq_pkg::*;
#(
  parameter int AW     = 19,
  parameter int SECT_W = 12
) (
  input  op_e           op_i,
  input  logic [2:0]    step_i,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    data_i,
  output logic [AW-1:0] waddr_o,
  output logic [7:0]    wdata_o,
  output logic          last_o
);
  localparam logic [AW-1:0] ADDR_A = AW'(UNLOCK_A);
  localparam logic [AW-1:0] ADDR_B = AW'(UNLOCK_B);
  localparam logic [AW-1:0] SECT_MASK = ~AW'((1 << SECT_W) - 1);

  logic is_prog;
  assign is_prog = (op_i == OP_PROG);
  assign last_o  = is_prog ? (step_i == 3'd3) : (step_i == 3'd5);

  always_comb begin
    waddr_o = ADDR_A;
    wdata_o = KEY_A;
    case (step_i)
      3'd0: begin waddr_o = ADDR_A; wdata_o = KEY_A; end
      3'd1: begin waddr_o = ADDR_B; wdata_o = KEY_B; end
      3'd2: begin waddr_o = ADDR_A; wdata_o = is_prog ? CMD_PROG : CMD_ERS; end
      3'd3: begin
        waddr_o = is_prog ? addr_i : ADDR_A;
        wdata_o = is_prog ? data_i : KEY_A;
      end
      3'd4: begin waddr_o = ADDR_B; wdata_o = KEY_B; end
      3'd5: begin
        waddr_o = (op_i == OP_SECT) ? (addr_i & SECT_MASK) : ADDR_A;
        wdata_o = (op_i == OP_SECT) ? CMD_SECT : CMD_BANK;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/flash_done_chk.sv
module flash_done_chk
  import flash_seq_pkg::*;
#(
  parameter int CONFIRM_N = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       rd_vld_i,
  input  logic [7:0] rd_data_i,
  input  poll_e      mode_i,
  input  logic       exp7_i,
  output logic       confirm_o,
  output logic       fail_o
);
  localparam int RW = $clog2(CONFIRM_N + 1);
  localparam logic [RW-1:0] RUN_MAX = RW'(CONFIRM_N);

  logic          have_q, prev6_q;
  logic [RW-1:0] run_q;
  logic          eval, pass;

  assign eval      = (mode_i == POLL_TOGGLE) ? have_q : 1'b1;
  assign pass      = (mode_i == POLL_TOGGLE) ? (rd_data_i[6] == prev6_q)
                                             : (rd_data_i[7] == exp7_i);
  assign confirm_o = rd_vld_i && eval && pass && (run_q == RUN_MAX);
  assign fail_o    = rd_vld_i && eval && !pass;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      have_q  <= 1'b0;
      prev6_q <= 1'b0;
      run_q   <= '0;
    end else if (clr_i) begin
      have_q  <= 1'b0;
      run_q   <= '0;
    end else if (rd_vld_i) begin
      have_q  <= 1'b1;
      prev6_q <= rd_data_i[6];
      if (eval) run_q <= !pass ? '0 : (run_q == RUN_MAX) ? RUN_MAX : run_q + 1'b1;
    end
  end

  // R6
  run_reset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fail_o && !clr_i) |=> (run_q == '0));
endmodule

// File: rtl/flash_tmo_cnt.sv
module flash_tmo_cnt #(
  parameter int TW = 24
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          en_i,
  input  logic [TW-1:0] limit_i,
  output logic          expired_o
);
  logic [TW-1:0] cnt_q;

  assign expired_o = ({1'b0, cnt_q} + 1'b1) >= {1'b0, limit_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (clr_i)              cnt_q <= '0;
    else if (en_i && !(&cnt_q))  cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/flash_seq_ctrl.sv
module flash_seq_ctrl
  import flash_seq_pkg::*;
#(
  parameter int AW        = 19,
  parameter int TW        = 24,
  parameter int SECT_W    = 12,
  parameter int CONFIRM_N = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic [1:0]    op_i,
  input  logic [1:0]    mode_i,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    data_i,
  input  logic [TW-1:0] tmo_prog_i,
  input  logic [TW-1:0] tmo_sect_i,
  input  logic [TW-1:0] tmo_bank_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          err_o,
  output logic          rej_o,
  output logic [AW-1:0] bus_addr_o,
  output logic [7:0]    bus_wdata_o,
  output logic          bus_we_o,
  output logic          bus_re_o,
  input  logic [7:0]    bus_rdata_i,
  input  logic          bus_rdy_i
);
  st_e           state_q;
  op_e           op_q;
  poll_e         mode_q;
  logic [2:0]    step_q;
  logic [AW-1:0] addr_q;
  logic [7:0]    data_q;
  logic [TW-1:0] limit_q;
  logic          done_q, err_q, rej_q;

  logic [AW-1:0] cmd_addr;
  logic [7:0]    cmd_data;
  logic          cmd_last, cmd_end, rd_vld;
  logic          confirm, fail, expired;
  op_e           op_in;
  poll_e         mode_in;
  logic [TW-1:0] limit_in;

  assign op_in   = (op_i == 2'd3) ? OP_BANK : op_e'(op_i);
  assign mode_in = (mode_i == 2'd3) ? POLL_WAIT : poll_e'(mode_i);
  always_comb begin
    case (op_in)
      OP_PROG: limit_in = tmo_prog_i;
      OP_SECT: limit_in = tmo_sect_i;
      default: limit_in = tmo_bank_i;
    endcase
  end

  flash_cmd_gen #(.AW(AW), .SECT_W(SECT_W)) i_cmd (
    .op_i(op_q), .step_i(step_q), .addr_i(addr_q), .data_i(data_q),
    .waddr_o(cmd_addr), .wdata_o(cmd_data), .last_o(cmd_last)
  );

  assign cmd_end = (state_q == S_CMD) && bus_rdy_i && cmd_last;
  assign rd_vld  = (state_q == S_READ) && bus_rdy_i;

  flash_done_chk #(.CONFIRM_N(CONFIRM_N)) i_chk (
    .clk_i, .rst_ni, .clr_i(cmd_end), .rd_vld_i(rd_vld), .rd_data_i(bus_rdata_i),
    .mode_i(mode_q), .exp7_i((op_q == OP_PROG) ? data_q[7] : 1'b1),
    .confirm_o(confirm), .fail_o(fail)
  );

  flash_tmo_cnt #(.TW(TW)) i_tmo (
    .clk_i, .rst_ni, .clr_i(cmd_end),
    .en_i((state_q == S_READ) || (state_q == S_WAIT)),
    .limit_i(limit_q), .expired_o(expired)
  );

  assign busy_o      = (state_q != S_IDLE);
  assign done_o      = done_q;
  assign err_o       = err_q;
  assign rej_o       = rej_q;
  assign bus_we_o    = (state_q == S_CMD);
  assign bus_re_o    = (state_q == S_READ);
  assign bus_addr_o  = (state_q == S_CMD) ? cmd_addr : addr_q;
  assign bus_wdata_o = cmd_data;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      op_q    <= OP_PROG;
      mode_q  <= POLL_TOGGLE;
      step_q  <= '0;
      addr_q  <= '0;
      data_q  <= '0;
      limit_q <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      rej_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      rej_q  <= req_i && (state_q != S_IDLE);
      case (state_q)
        S_IDLE: if (req_i) begin
          op_q    <= op_in;
          mode_q  <= mode_in;
          addr_q  <= addr_i;
          data_q  <= data_i;
          limit_q <= limit_in;
          step_q  <= '0;
          state_q <= S_CMD;
        end
        S_CMD: if (bus_rdy_i) begin
          if (cmd_last) state_q <= (mode_q == POLL_WAIT) ? S_WAIT : S_READ;
          else          step_q  <= step_q + 1'b1;
        end
        S_READ: if (bus_rdy_i) begin
          // a pass run in progress is never cut by the limit
          if (confirm) begin
            done_q  <= 1'b1;
            state_q <= S_IDLE;
          end else if (fail && expired) begin
            err_q   <= 1'b1;
            state_q <= S_IDLE;
          end
        end
        S_WAIT: if (expired) begin
          done_q  <= 1'b1;
          state_q <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  // R11
  wr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_o && !bus_rdy_i) |=> (bus_we_o && $stable(bus_addr_o) && $stable(bus_wdata_o)));
  // R11
  rd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_re_o && !bus_rdy_i) |=> (bus_re_o && $stable(bus_addr_o)));
  // R9
  rej_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rej_o |-> $past(busy_o));
  // R12
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o || err_o) |-> !busy_o);
  // R7
  err_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (!done_o && $past(bus_re_o)));
  // R8
  wait_noread_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == POLL_WAIT) |-> !bus_re_o);
endmodule

// File: tb/test_flash_seq_ctrl.sv
`timescale 1ns/1ps
module test_flash_seq_ctrl;
  localparam int AW = 19;
  localparam int TW = 24;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          req_i = 1'b0;
  logic [1:0]    op_i = '0, mode_i = '0;
  logic [AW-1:0] addr_i = '0;
  logic [7:0]    data_i = '0;
  logic [TW-1:0] tmo_prog_i = '0, tmo_sect_i = '0, tmo_bank_i = '0;
  logic          busy_o, done_o, err_o, rej_o;
  logic [AW-1:0] bus_addr_o;
  logic [7:0]    bus_wdata_o;
  logic          bus_we_o, bus_re_o;
  logic [7:0]    bus_rdata_i = '0;
  logic          bus_rdy_i = 1'b0;

  flash_seq_ctrl #(.AW(AW), .TW(TW)) i_flash_seq_ctrl (.*);

  always #2.5 clk_i = ~clk_i;

  int n_chk = 0, n_err = 0;
  bit finished = 0;

  // flash model state
  int            m_b, m_g, rd_idx, nwr, bad_rd, ovl, cyc, wcnt;
  logic [7:0]    m_true;
  logic [AW-1:0] m_addr;
  logic [AW-1:0] log_a [0:15];
  logic [7:0]    log_d [0:15];
  logic          cap_we;
  logic [AW-1:0] cap_a;
  logic [7:0]    cap_d;

  task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] fval(int idx);
    logic b6, b7;
    if (idx >= m_b) return m_true;
    b6 = idx[0];
    b7 = ~m_true[7];
    if (idx == m_g && idx > 0) begin
      b6 = ((idx - 1) % 2) != 0;
      b7 = m_true[7];
    end
    return {b7, b6, m_true[5:0]};
  endfunction

  // reference walk: read count at success, -1 if none
  function automatic int exp_reads(int mode);
    logic [7:0] v;
    logic p6 = 1'b0;
    bit have = 0, ev, ps;
    int run = 0;
    for (int i = 0; i < 300; i++) begin
      v  = fval(i);
      ev = (mode == 0) ? have : 1;
      ps = (mode == 0) ? (v[6] == p6) : (v[7] == m_true[7]);
      if (ev && ps) begin
        if (run == 2) return i + 1;
        run++;
      end else if (ev) run = 0;
      p6 = v[6];
      have = 1;
    end
    return -1;
  endfunction

  function automatic logic [AW-1:0] exp_wa(int op, int i, logic [AW-1:0] a);
    if (op == 0 && i == 3) return a;
    if (i == 1 || i == 4) return AW'(15'h2AAA);
    if (i == 5 && op == 1) return {a[AW-1:12], 12'h000};
    return AW'(15'h5555);
  endfunction

  function automatic logic [7:0] exp_wd(int op, int i, logic [7:0] d);
    case (i)
      0, 3: return (op == 0 && i == 3) ? d : 8'hAA;
      1, 4: return 8'h55;
      2:    return (op == 0) ? 8'hA0 : 8'h80;
      default: return (op == 1) ? 8'h30 : 8'h10;
    endcase
  endfunction

  // bus slave model, acts at negedges
  initial begin
    wcnt = 0;
    forever begin
      @(negedge clk_i);
      cyc++;
      if (bus_we_o && bus_re_o) ovl++;
      if (bus_rdy_i) begin
        if (cap_we) begin
          if (nwr < 16) begin log_a[nwr] = cap_a; log_d[nwr] = cap_d; end
          nwr++;
          cyc = 0;
        end else begin
          if (cap_a != m_addr) bad_rd++;
          rd_idx++;
        end
        bus_rdy_i = 1'b0;
        wcnt = $urandom % 3;
      end else if (bus_we_o || bus_re_o) begin
        if (wcnt == 0) begin
          bus_rdy_i   = 1'b1;
          cap_we      = bus_we_o;
          cap_a       = bus_addr_o;
          cap_d       = bus_wdata_o;
          bus_rdata_i = fval(rd_idx);
        end else wcnt--;
      end
    end
  end

  task automatic run_op(input int op, input int mode, input logic [AW-1:0] a, input logic [7:0] d,
                        input int lim, input int b, input int g, input bit do_rej, input string req);
    int  er, it, nbad;
    bit  got_done = 0, got_err = 0;
    m_b = b; m_g = g; m_addr = a;
    m_true = (op == 0) ? d : 8'hFF;
    rd_idx = 0; nwr = 0; bad_rd = 0; cyc = 0;
    er = (mode >= 2) ? 0 : exp_reads(mode);
    tmo_prog_i = TW'(lim); tmo_sect_i = TW'(lim); tmo_bank_i = TW'(lim);
    op_i = 2'(op); mode_i = 2'(mode); addr_i = a; data_i = d;
    req_i = 1'b1;
    @(negedge clk_i); #1;
    req_i = 1'b0;
    chk(busy_o == 1'b1, "R12", "busy after request", busy_o, 1);
    for (it = 0; it < 6000; it++) begin
      if (done_o) got_done = 1;
      if (err_o) got_err = 1;
      if (got_done || got_err) break;
      if (do_rej && it == 2) begin
        req_i = 1'b1; op_i = 2'((op + 1) % 3); addr_i = ~a;
      end
      if (do_rej && it == 3) begin
        req_i = 1'b0;
        chk(rej_o == 1'b1, "R9", "reject pulse", rej_o, 1);
      end
      @(negedge clk_i); #1;
    end
    chk(busy_o == 1'b0, "R12", "idle at end", busy_o, 0);
    begin
      int nexp = (op == 0) ? 4 : 6;
      string wr = (op == 0) ? "R1" : (op == 1) ? "R2" : "R3";
      chk(nwr == nexp, wr, "write count", nwr, nexp);
      nbad = 0;
      for (int i = 0; i < nexp && i < nwr; i++)
        if (log_a[i] != exp_wa(op, i, a) || log_d[i] != exp_wd(op, i, d)) begin
          if (nbad == 0) chk(0, wr, $sformatf("write %0d addr/data", i),
                             {log_a[i], log_d[i]}, {exp_wa(op, i, a), exp_wd(op, i, d)});
          nbad++;
        end
      if (nbad == 0) chk(1, wr, "writes", 0, 0);
    end
    if (mode >= 2) begin
      chk(got_done && !got_err, "R8", "timed done", got_done, 1);
      chk(rd_idx == 0, "R8", "no reads", rd_idx, 0);
      chk(cyc == ((lim == 0) ? 1 : lim), "R8", "timed delay", cyc, lim);
    end else if (er < 0) begin
      chk(got_err && !got_done, "R7", "timeout error", got_err, 1);
      chk(cyc >= lim && cyc <= lim + 8, "R7", "timeout delay", cyc, lim);
    end else begin
      chk(got_done && !got_err, req, "done outcome", {got_err, got_done}, 1);
      chk(rd_idx == er, "R6", "reads to confirm", rd_idx, er);
      chk(bad_rd == 0, "R4", "poll address", bad_rd, 0);
    end
  endtask

  task automatic finish_run();
    if (finished) return;
    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    for (int i = 0; i < 190000; i++) @(posedge clk_i);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=expired expected=finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4711));
    m_b = 0; m_g = -1; m_true = 0; m_addr = 0; ovl = 0;
    repeat (3) @(negedge clk_i);
    #1;
    chk(!busy_o && !done_o && !err_o && !rej_o && !bus_we_o && !bus_re_o, "R12", "reset state",
        {busy_o, done_o, err_o, rej_o, bus_we_o, bus_re_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i); #1;

    run_op(0, 0, 19'h12345, 8'h5C, 5000, 3, -1, 0, "R4");
    run_op(1, 0, 19'h7ABCD, 8'h00, 5000, 5, -1, 0, "R4");
    run_op(2, 1, 19'h01234, 8'h00, 5000, 4, -1, 0, "R5");
    run_op(0, 1, 19'h00FF1, 8'h3A, 5000, 3, -1, 0, "R5");
    run_op(0, 1, 19'h00FF2, 8'hC1, 5000, 2, -1, 0, "R5");
    run_op(0, 1, 19'h11111, 8'h9E, 5000, 5, 2, 0, "R6");
    run_op(1, 0, 19'h22222, 8'h00, 5000, 6, 3, 0, "R6");
    run_op(0, 2, 19'h33333, 8'h44, 7, 0, -1, 0, "R8");
    run_op(2, 3, 19'h00000, 8'h00, 1, 0, -1, 0, "R8");
    run_op(0, 0, 19'h44444, 8'h12, 150, 1000000, -1, 0, "R7");
    run_op(1, 1, 19'h55555, 8'h00, 40, 1000000, -1, 0, "R7");
    run_op(0, 1, 19'h66666, 8'hF0, 1, 0, -1, 0, "R10");
    run_op(2, 0, 19'h77777, 8'h00, 1, 0, -1, 0, "R10");
    run_op(1, 2, 19'h0ABCD, 8'h00, 30, 0, -1, 1, "R9");
    run_op(0, 0, 19'h1F00F, 8'h81, 5000, 4, -1, 1, "R9");

    for (int k = 0; k < 16; k++) begin
      int op = $urandom % 3;
      int md = $urandom % 2;
      int b  = $urandom % 7;
      int g  = ($urandom % 2) ? int'($urandom % 7) : -1;
      run_op(op, md, AW'($urandom), 8'($urandom), 5000, b, g, 0, md ? "R5" : "R4");
    end

    chk(ovl == 0, "R11", "strobe overlap", ovl, 0);
    finish_run();
  end
endmodule